// File: doc/BRIEF.md
# Primary Interrupt Aggregator

This block sits at the top of a two-level interrupt tree. Up to eight secondary interrupt banks each raise a request, separately for each of two host interrupt lines. For every line the aggregator forms one live status byte: bit n is set while bank n requests on that line, or while software forces bit n through the test register. Each line drives its own active-low interrupt pin, which is low while any bit of that line's status byte is set.

There is no masking here. A host turns sources off in the secondary banks. Once a bank's request drops, the matching status bit clears on its own. The status bytes are not stored, so nothing at this level has to be acknowledged. Software reads and writes the block through a simple register port. Read data is returned one cycle after the read strobe. Writes take effect at the clock edge that samples them.

Top module: `pia_top`

## Requirements
- R1: A read of offset 0x01 returns the line-1 status byte, with bit n equal to bank n's line-1 request OR test bit n.
- R2: A read of offset 0x02 returns the line-2 status byte. Line-1 requests never set line-2 status bits, and line-2 requests never set line-1 status bits.
- R3: Status and test bits at positions NUM_BANKS and above (bits 6 and 7 by default) always read 0, even after software writes 1 to them.
- R4: No mask exists. A status bit follows its request with no acknowledge: it reads 1 while the request is high and 0 once the request falls.
- R5: irq_n[k] is 1 after reset. It is 0 one clock after any line-(k+1) status bit is set, and returns to 1 one clock after all of them clear.
- R6: Writing offset 0x03 loads the test register (bit n forces status bit n on both lines). A read of 0x03 returns it. Each bit holds until software writes 0 to it.
- R7: Reads of unmapped offsets (any offset other than 0x01, 0x02 and 0x03) return 0. Writes to unmapped offsets leave the test register unchanged.
- R8: reg_rd_data carries the addressed value in the cycle after reg_rd_en is sampled high, and 0 in the cycle after it is sampled low.
- R9: Writes to the status offsets 0x01 and 0x02 have no effect on status or on the test register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_req_l1 | input | NUM_BANKS | Secondary bank requests for line 1, bit n from bank n |
| bank_req_l2 | input | NUM_BANKS | Secondary bank requests for line 2, bit n from bank n |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 8 | Read data, valid one cycle after reg_rd_en |
| irq_n | output | 2 | Active-low interrupt pins, bit 0 for line 1 and bit 1 for line 2 |

## Verification
The only state in the block is the test register and the two registered pins. A corrupted test bit therefore shows up on the very next read of 0x03. It also shows on a status read of either line, and it drives both pins low one clock later. A wrong pin register shows as irq_n disagreeing with the status byte that was readable one cycle earlier. Cross-wired lines or bank positions show on the first status read after a single request is raised. For this reason the tests raise one bank and one line at a time.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int REG_W = 8;
  localparam int LINES = 2;
  typedef logic [REG_W-1:0] reg_t;

  localparam reg_t OFS_STAT_L1 = 8'h01;
  localparam reg_t OFS_STAT_L2 = 8'h02;
  localparam reg_t OFS_TEST    = 8'h03;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_L1   = 2'd1,
    SEL_L2   = 2'd2,
    SEL_TEST = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input reg_t a);
    case (a)
      OFS_STAT_L1: return SEL_L1;
      OFS_STAT_L2: return SEL_L2;
      OFS_TEST:    return SEL_TEST;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pia_test_reg.sv
module pia_test_reg
  import pia_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_sel_e             sel,
  input  reg_t                 wr_data,
  output logic [NUM_BANKS-1:0] test_q
);
  // Only populated positions are stored; upper bits are dropped on write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      test_q <= '0;
    else if (wr_en && sel == SEL_TEST)
      test_q <= wr_data[NUM_BANKS-1:0];
  end
endmodule

// File: rtl/pia_line_merge.sv
module pia_line_merge
  import pia_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] req,
  input  logic [NUM_BANKS-1:0] force_bits,
  output reg_t                 status,
  output logic                 pin_n
);
  // Live status: no storage, no mask.
  always_comb begin
    status = '0;
    status[NUM_BANKS-1:0] = req | force_bits;
  end

  // Registered pin to keep the external line glitch free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_n <= 1'b1;
    else
      pin_n <= ~(|status);
  end
endmodule

// File: rtl/pia_read_port.sv
module pia_read_port
  import pia_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  reg_sel_e             sel,
  input  reg_t                 stat_l1,
  input  reg_t                 stat_l2,
  input  logic [NUM_BANKS-1:0] test_q,
  output reg_t                 rd_data
);
  reg_t rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_L1:   rd_mux = stat_l1;
      SEL_L2:   rd_mux = stat_l2;
      SEL_TEST: rd_mux[NUM_BANKS-1:0] = test_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else
      rd_data <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/pia_top.sv
module pia_top
  import pia_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_req_l1,
  input  logic [NUM_BANKS-1:0] bank_req_l2,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr_en,
  input  logic [7:0]           reg_wr_data,
  input  logic                 reg_rd_en,
  output logic [7:0]           reg_rd_data,
  output logic [1:0]           irq_n
);
  reg_sel_e             sel;
  logic [NUM_BANKS-1:0] test_q;
  logic [NUM_BANKS-1:0] req_arr [LINES];
  reg_t                 stat_arr [LINES];

  assign sel        = decode_ofs(reg_addr);
  assign req_arr[0] = bank_req_l1;
  assign req_arr[1] = bank_req_l2;

  pia_test_reg #(.NUM_BANKS(NUM_BANKS)) u_test (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(sel),
    .wr_data(reg_wr_data), .test_q(test_q)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    pia_line_merge #(.NUM_BANKS(NUM_BANKS)) u_merge (
      .clk(clk), .rst_n(rst_n), .req(req_arr[g]), .force_bits(test_q),
      .status(stat_arr[g]), .pin_n(irq_n[g])
    );
  end

  pia_read_port #(.NUM_BANKS(NUM_BANKS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd_en), .sel(sel),
    .stat_l1(stat_arr[0]), .stat_l2(stat_arr[1]), .test_q(test_q),
    .rd_data(reg_rd_data)
  );
endmodule

// File: rtl/pia_checker.sv
module pia_checker #(
  parameter int NUM_BANKS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_req_l1,
  input logic [NUM_BANKS-1:0] bank_req_l2,
  input logic [7:0]           reg_addr,
  input logic                 reg_wr_en,
  input logic                 reg_rd_en,
  input logic [7:0]           reg_rd_data,
  input logic [1:0]           irq_n,
  input logic [NUM_BANKS-1:0] test_q
);
  logic [NUM_BANKS-1:0] l1_live, l2_live;
  assign l1_live = bank_req_l1 | test_q;
  assign l2_live = bank_req_l2 | test_q;

  assert_pin_l1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_n[0] == ($past(l1_live) == '0));
  assert_pin_l2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_n[1] == ($past(l2_live) == '0));
  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> reg_rd_data == 8'h00);
  assert_unpopulated_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> (reg_rd_data >> NUM_BANKS) == 8'h00);
  assert_test_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == 8'h03) |=> $stable(test_q));
  assert_l1_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == 8'h01) |=> reg_rd_data[NUM_BANKS-1:0] == $past(l1_live));
  assert_l2_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == 8'h02) |=> reg_rd_data[NUM_BANKS-1:0] == $past(l2_live));
endmodule

bind pia_top pia_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_req_l1(bank_req_l1), .bank_req_l2(bank_req_l2),
  .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_rd_data(reg_rd_data), .irq_n(irq_n), .test_q(test_q)
);

// File: tb/pia_top_bench.sv
`timescale 1ns/1ps
module pia_top_bench;
  localparam int NB = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] bank_req_l1 = '0, bank_req_l2 = '0;
  logic [7:0] reg_addr = '0, reg_wr_data = '0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0] reg_rd_data;
  logic [1:0] irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pia_top #(.NUM_BANKS(NB)) u_pia_top (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rd_data;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R5 reset pins", irq_n, 2'b11);
    chk("R8 reset rd_data", reg_rd_data, 0);
    reg_rd(8'h03, d); chk("R6 reset test reg", d, 0);
  endtask

  task automatic t_line1_map;
    logic [7:0] d;
    for (int n = 0; n < NB; n++) begin
      @(negedge clk); bank_req_l1 = NB'(1 << n);
      reg_rd(8'h01, d); chk("R1 line1 bit position", d, 1 << n);
      reg_rd(8'h02, d); chk("R2 line2 untouched by line1", d, 0);
    end
    @(negedge clk); bank_req_l1 = '0;
  endtask

  task automatic t_line2_map;
    logic [7:0] d;
    @(negedge clk); bank_req_l2 = 6'b100101;
    reg_rd(8'h02, d); chk("R2 line2 status", d, 8'h25);
    reg_rd(8'h01, d); chk("R2 line1 untouched by line2", d, 0);
    chk("R5 line2 pin low, line1 high", irq_n, 2'b01);
    @(negedge clk); bank_req_l2 = '0;
  endtask

  task automatic t_live_clear;
    logic [7:0] d;
    @(negedge clk); bank_req_l1 = 6'b001010;
    reg_rd(8'h01, d); chk("R4 live set", d, 8'h0A);
    @(negedge clk); bank_req_l1 = 6'b000010;
    reg_rd(8'h01, d); chk("R4 partial clear", d, 8'h02);
    @(negedge clk); bank_req_l1 = '0;
    reg_rd(8'h01, d); chk("R4 full clear, no ack", d, 0);
  endtask

  task automatic t_pin;
    @(negedge clk); bank_req_l1 = 6'b010000;
    chk("R5 pin before edge", irq_n[0], 1);
    @(negedge clk); chk("R5 pin low one clock later", irq_n[0], 0);
    bank_req_l1 = '0;
    @(negedge clk); chk("R5 pin released one clock later", irq_n[0], 1);
  endtask

  task automatic t_test_reg;
    logic [7:0] d;
    reg_wr(8'h03, 8'hFF);
    reg_rd(8'h03, d); chk("R3 test upper bits read zero", d, 8'h3F);
    reg_rd(8'h01, d); chk("R3 line1 upper bits zero", d, 8'h3F);
    reg_rd(8'h02, d); chk("R6 test forces line2", d, 8'h3F);
    chk("R6 forced pins low", irq_n, 2'b00);
    repeat (3) @(negedge clk);
    reg_rd(8'h03, d); chk("R6 test bits hold", d, 8'h3F);
    reg_wr(8'h03, 8'h04);
    reg_rd(8'h01, d); chk("R6 partial clear by writing 0", d, 8'h04);
    reg_wr(8'h03, 8'h00);
    reg_rd(8'h01, d); chk("R6 cleared", d, 0);
    @(negedge clk); chk("R5 pins released after clear", irq_n, 2'b11);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    @(negedge clk); bank_req_l1 = 6'b111111; bank_req_l2 = 6'b111111;
    reg_wr(8'h03, 8'h01);
    reg_rd(8'h00, d); chk("R7 offset 0x00 reads zero", d, 0);
    reg_rd(8'h04, d); chk("R7 offset 0x04 reads zero", d, 0);
    reg_rd(8'hFF, d); chk("R7 offset 0xFF reads zero", d, 0);
    reg_wr(8'h07, 8'h3E);
    reg_rd(8'h03, d); chk("R7 unmapped write ignored", d, 8'h01);
    reg_wr(8'h01, 8'h00); reg_wr(8'h02, 8'h3C);
    reg_rd(8'h03, d); chk("R9 status write leaves test", d, 8'h01);
    reg_rd(8'h01, d); chk("R9 line1 status unaffected", d, 8'h3F);
    @(negedge clk); bank_req_l1 = '0; bank_req_l2 = '0;
    reg_rd(8'h02, d); chk("R9 line2 shows only test bit", d, 8'h01);
    reg_wr(8'h03, 8'h00);
  endtask

  task automatic t_read_timing;
    @(negedge clk); bank_req_l1 = 6'b000001; reg_addr = 8'h01; reg_rd_en = 1'b1;
    chk("R8 data not before edge", reg_rd_data, 0);
    @(negedge clk); reg_rd_en = 1'b0;
    chk("R8 data one cycle after strobe", reg_rd_data, 1);
    @(negedge clk); chk("R8 zero when strobe low", reg_rd_data, 0);
    bank_req_l1 = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_line1_map;
    t_line2_map;
    t_live_clear;
    t_pin;
    t_test_reg;
    t_unmapped;
    t_read_timing;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule